// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits between a system bus and a byte-wide flash array. It watches bus writes to three fixed command addresses in the lowest 64 KB bank and matches the bytes written there as multi-byte unlock sequences. Three mode flags come out of the matching: status mode, identification mode and program mode. These flags decide whether a bus read returns a status byte, a byte from a fixed identification table, or the array data. They also decide whether a bus write reaches the array.

The array is outside the block. The block only forwards the address, write data and strobes to the array ports, and it passes the array read data back to the bus when no override applies. A read-only strap input turns off every effect of a write, both array writes and command bytes. Array reads take no clock cycle: `rdata_o` follows the address in the same cycle. Writes take effect at the rising edge of `clk_i` while `we_i` is high.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset all three modes are off, reads return `arr_rdata_i` unchanged, `rdata_o` is 0x00 while `re_i` is low, and no write reaches the array.
- R2: A write of 0xD0 to address 0x000000 whose previous command byte was 0x38 turns on status mode and identification mode.
- R3: While status mode is on, a read of address 0x000002 or 0x005555 returns 0x80. Other addresses are not affected.
- R4: While identification mode is on, a read of address 0x00FF00+i, for i from 0 to 0x13, returns 0x4D when i=0, 0x50 when i=2, 0x2A when i=6, and 0x00 otherwise. Addresses outside that window return array data.
- R5: The command bytes 0xAA, 0x55, 0xA0, with the last one written to 0x005555, turn on status mode and program mode and reset the stored previous data byte to 0x00.
- R6: The command bytes 0xAA, 0x55, 0x70, with the last one written to 0x005555, turn off program mode only.
- R7: The command bytes 0xAA, 0x55, 0xF0, with the last one written to 0x005555, turn off all three modes.
- R8: A write to bank 0x00 (address bits 23:16 all zero) reaches the array only when program mode is on and the write data equals the data of the previous bank-0 write. Every accepted bank-0 write stores its data as the new previous byte.
- R9: A write to any other bank reaches the array whenever program mode is on, and it leaves the stored previous byte unchanged.
- R10: While `ro_strap_i` is high, a write changes nothing: no array write, no mode change, no command byte and no stored data.
- R11: A write that reaches the array is not taken as a command byte.
- R12: Command bytes are only the writes to 0x000000, 0x002AAA and 0x005555. Writes to other addresses leave the sequence history as it was. Sequences are matched only at the address their last byte needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address, bank in bits 23:16 |
| wdata_i | input | 8 | Bus write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (status, ID or array byte) |
| ro_strap_i | input | 1 | Read-only strap, blocks all writes |
| arr_addr_o | output | 24 | Array address |
| arr_wdata_o | output | 8 | Array write data |
| arr_we_o | output | 1 | Array write enable |
| arr_re_o | output | 1 | Array read enable |
| arr_rdata_i | input | 8 | Array read data |

## Verification
A wrong command history shows up at the ports only when a sequence is completed. A wrong history makes 0x5555 or 0x0002 read back 0x80, or stop reading back 0x80, on the first read after the final command byte. A wrong stored previous byte shows up on the next bank-0 write while program mode is on: `arr_we_o` fires too early or not at all in that same cycle. A stray mode flag shows up in the same cycle at the next read of a status or ID address, or at the next write to another bank.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned BUS_AW = 24;
  localparam int unsigned BUS_DW = 8;

  localparam logic [15:0] OFS_CMD_A  = 16'h0000;
  localparam logic [15:0] OFS_CMD_B  = 16'h2AAA;
  localparam logic [15:0] OFS_CMD_C  = 16'h5555;
  localparam logic [15:0] OFS_STAT   = 16'h0002;
  localparam logic [15:0] OFS_ID_LO  = 16'hFF00;
  localparam logic [15:0] OFS_ID_HI  = 16'hFF13;

  localparam logic [7:0]  STAT_BYTE  = 8'h80;
  localparam logic [15:0] SEQ_ID_ON  = 16'h38D0;
  localparam logic [23:0] SEQ_PG_OFF = 24'hAA5570;
  localparam logic [23:0] SEQ_PG_ON  = 24'hAA55A0;
  localparam logic [23:0] SEQ_ALLOFF = 24'hAA55F0;

  typedef struct packed {
    logic stat;
    logic id;
    logic prog;
  } mode_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ID_ON,
    CMD_PG_OFF,
    CMD_PG_ON,
    CMD_ALL_OFF
  } cmd_e;

  function automatic logic [7:0] id_byte(input logic [4:0] idx);
    case (idx)
      5'd0:    id_byte = 8'h4D;
      5'd2:    id_byte = 8'h50;
      5'd6:    id_byte = 8'h2A;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/flash_cmd_hist.sv
module flash_cmd_hist #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HIST_BYTES = 3,
  localparam int unsigned HW        = DATA_W * HIST_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [HW-1:0]     hist_o,
  output logic [HW-1:0]     hist_nxt_o
);
  logic [HW-1:0] hist_q;

  generate
    if (HIST_BYTES > 1) begin : g_multi
      assign hist_nxt_o = {hist_q[HW-DATA_W-1:0], byte_i};
    end else begin : g_single
      assign hist_nxt_o = byte_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_nxt_o;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned HW = 24
) (
  input  logic          shift_i,
  input  logic [15:0]   ofs_i,
  input  logic [HW-1:0] hist_nxt_i,
  output cmd_e          cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (shift_i) begin
      if (ofs_i == OFS_CMD_A) begin
        if (hist_nxt_i[15:0] == SEQ_ID_ON) cmd_o = CMD_ID_ON;
      end else if (ofs_i == OFS_CMD_C) begin
        unique case (hist_nxt_i[23:0])
          SEQ_PG_OFF: cmd_o = CMD_PG_OFF;
          SEQ_PG_ON:  cmd_o = CMD_PG_ON;
          SEQ_ALLOFF: cmd_o = CMD_ALL_OFF;
          default:    cmd_o = CMD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cmd_e  cmd_i,
  output mode_t mode_o
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    case (cmd_i)
      CMD_ID_ON:   begin mode_d.stat = 1'b1; mode_d.id = 1'b1; end
      CMD_PG_ON:   begin mode_d.stat = 1'b1; mode_d.prog = 1'b1; end
      CMD_PG_OFF:  mode_d.prog = 1'b0;
      CMD_ALL_OFF: mode_d = '0;
      default:     ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              re_i,
  input  logic              bank0_i,
  input  logic [15:0]       ofs_i,
  input  mode_t             mode_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic stat_hit, id_hit;
  logic [15:0] id_idx;

  assign stat_hit = mode_i.stat && bank0_i && (ofs_i == OFS_STAT || ofs_i == OFS_CMD_C);
  assign id_hit   = mode_i.id && bank0_i && ofs_i >= OFS_ID_LO && ofs_i <= OFS_ID_HI;
  assign id_idx   = ofs_i - OFS_ID_LO;

  always_comb begin
    if (!re_i)         rdata_o = '0;
    else if (stat_hit) rdata_o = DATA_W'(STAT_BYTE);
    else if (id_hit)   rdata_o = DATA_W'(id_byte(id_idx[4:0]));
    else               rdata_o = arr_rdata_i;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = BUS_AW,
  parameter int unsigned DATA_W     = BUS_DW,
  parameter int unsigned HIST_BYTES = 3,
  localparam int unsigned HW        = DATA_W * HIST_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ro_strap_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              arr_we_o,
  output logic              arr_re_o,
  input  logic [DATA_W-1:0] arr_rdata_i
);
  logic              wr_ok, bank0, magic, pgm_hit, shift;
  logic [15:0]       ofs;
  logic [DATA_W-1:0] prev_q;
  logic [HW-1:0]     cmd_hist, cmd_hist_nxt;
  logic [23:0]       hist_lo;
  cmd_e              cmd;
  mode_t             mode;

  assign ofs   = addr_i[15:0];
  assign bank0 = (addr_i[ADDR_W-1:16] == '0);
  assign wr_ok = we_i && !ro_strap_i;
  assign magic = bank0 && (ofs == OFS_CMD_A || ofs == OFS_CMD_B || ofs == OFS_CMD_C);

  // bank 0 needs the same byte twice in a row; other banks program directly
  assign pgm_hit = wr_ok && mode.prog && (!bank0 || wdata_i == prev_q);
  assign shift   = wr_ok && !pgm_hit && magic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prev_q <= '0;
    else if (cmd == CMD_PG_ON)   prev_q <= '0;
    else if (wr_ok && bank0)     prev_q <= wdata_i;
  end

  flash_cmd_hist #(.DATA_W(DATA_W), .HIST_BYTES(HIST_BYTES)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .byte_i     (wdata_i),
    .hist_o     (cmd_hist),
    .hist_nxt_o (cmd_hist_nxt)
  );

  flash_cmd_decode #(.HW(HW)) u_dec (
    .shift_i    (shift),
    .ofs_i      (ofs),
    .hist_nxt_i (cmd_hist_nxt),
    .cmd_o      (cmd)
  );

  flash_cmd_mode u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .mode_o (mode)
  );

  flash_cmd_rdmux #(.DATA_W(DATA_W)) u_rd (
    .re_i        (re_i),
    .bank0_i     (bank0),
    .ofs_i       (ofs),
    .mode_i      (mode),
    .arr_rdata_i (arr_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign hist_lo     = cmd_hist[23:0];
  assign arr_addr_o  = addr_i;
  assign arr_wdata_o = wdata_i;
  assign arr_we_o    = pgm_hit;
  assign arr_re_o    = re_i;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [23:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic        we_i,
  input logic        re_i,
  input logic [7:0]  rdata_o,
  input logic        ro_strap_i,
  input logic        arr_we_o,
  input logic [23:0] hist_i,
  input logic        stat_i,
  input logic        id_i,
  input logic        prog_i
);
  logic cmd_wr;
  assign cmd_wr = we_i && !ro_strap_i && !arr_we_o && addr_i == 24'h005555;

  p_ro_no_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_strap_i |-> !arr_we_o);

  p_ro_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_strap_i |=> ($stable(hist_i) && $stable({stat_i, id_i, prog_i})));

  p_we_needs_prog_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |-> !arr_we_o);

  p_pgm_no_shift_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> $stable(hist_i));

  p_all_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && {hist_i[15:0], wdata_i} == 24'hAA55F0) |=> !(stat_i || id_i || prog_i));

  p_prog_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && {hist_i[15:0], wdata_i} == 24'hAA55A0) |=> (stat_i && prog_i));

  p_status_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && stat_i && addr_i == 24'h000002) |-> rdata_o == 8'h80);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .we_i       (we_i),
  .re_i       (re_i),
  .rdata_o    (rdata_o),
  .ro_strap_i (ro_strap_i),
  .arr_we_o   (arr_we_o),
  .hist_i     (hist_lo),
  .stat_i     (mode.stat),
  .id_i       (mode.id),
  .prog_i     (mode.prog)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0, ro = 1'b0;
  logic [7:0]  rdata, arr_wdata, arr_rdata;
  logic [23:0] arr_addr;
  logic        arr_we, arr_re;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // array model: data is a function of the low address byte
  assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

  flash_cmd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .ro_strap_i(ro), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .arr_we_o(arr_we), .arr_re_o(arr_re),
    .arr_rdata_i(arr_rdata)
  );

  function automatic logic [7:0] arr_of(input logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d, input logic exp_we, input string tag);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    #1;
    chk(arr_we === exp_we, tag, int'(arr_we), int'(exp_we));
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1;
    chk(rdata === exp, tag, int'(rdata), int'(exp));
    @(posedge clk);
    #1 re = 1'b0;
  endtask

  task automatic seq3(input logic [7:0] last);
    wr(24'h005555, 8'hAA, 1'b0, "seq");
    wr(24'h002AAA, 8'h55, 1'b0, "seq");
    wr(24'h005555, last,  1'b0, "seq");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk(rdata === 8'h00, "R1 idle rdata", int'(rdata), 0);
    rd(24'h005555, arr_of(24'h005555), "R1 status off");
    rd(24'h000002, arr_of(24'h000002), "R1 status off");
    rd(24'h00FF00, arr_of(24'h00FF00), "R1 id off");
    wr(24'h011234, 8'h12, 1'b0, "R1 no program");

    // R2 id/status enable
    wr(24'h000000, 8'h38, 1'b0, "R2");
    wr(24'h000000, 8'hD0, 1'b0, "R2");
    rd(24'h000002, 8'h80, "R3 status 0002");
    rd(24'h005555, 8'h80, "R3 status 5555");
    rd(24'h000003, arr_of(24'h000003), "R3 neighbour");
    rd(24'h015555, arr_of(24'h015555), "R3 other bank");

    // R4 id window sweep
    for (int i = 0; i <= 'h13; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h4D : (i == 2) ? 8'h50 : (i == 6) ? 8'h2A : 8'h00;
      rd(24'h00FF00 + 24'(i), e, "R4 id table");
    end
    rd(24'h00FF14, arr_of(24'h00FF14), "R4 above window");
    rd(24'h00FEFF, arr_of(24'h00FEFF), "R4 below window");
    rd(24'h01FF00, arr_of(24'h01FF00), "R4 other bank");

    // R7 all off
    seq3(8'hF0);
    rd(24'h005555, arr_of(24'h005555), "R7 status off");
    rd(24'h00FF00, arr_of(24'h00FF00), "R7 id off");

    // R5 program on
    seq3(8'hA0);
    rd(24'h000002, 8'h80, "R5 status on");
    rd(24'h00FF00, arr_of(24'h00FF00), "R5 id stays off");
    wr(24'h001234, 8'h00, 1'b1, "R5 prev cleared");
    wr(24'h001234, 8'h77, 1'b0, "R8 first");
    wr(24'h001234, 8'h77, 1'b1, "R8 repeat");
    wr(24'h001234, 8'h78, 1'b0, "R8 differs");
    wr(24'h021234, 8'h99, 1'b1, "R9 other bank");
    wr(24'h7F0000, 8'h01, 1'b1, "R9 other bank");
    wr(24'h001234, 8'h78, 1'b1, "R9 prev untouched");

    // R11 programmed byte is not a command byte
    wr(24'h005555, 8'hAA, 1'b0, "R11 seq");
    wr(24'h002AAA, 8'h55, 1'b0, "R11 seq");
    wr(24'h002AAA, 8'h55, 1'b1, "R11 programs");
    wr(24'h005555, 8'hF0, 1'b0, "R11 seq");
    rd(24'h000002, arr_of(24'h000002), "R11 all off");
    wr(24'h021234, 8'h01, 1'b0, "R11 prog off");

    // R6 program off only
    seq3(8'hA0);
    wr(24'h021234, 8'h01, 1'b1, "R6 prog on");
    seq3(8'h70);
    wr(24'h021234, 8'h01, 1'b0, "R6 prog off");
    rd(24'h000002, 8'h80, "R6 status kept");

    // R12 history only on command addresses
    seq3(8'hF0);
    wr(24'h005555, 8'hAA, 1'b0, "R12");
    wr(24'h002AAA, 8'h55, 1'b0, "R12");
    wr(24'h003000, 8'h11, 1'b0, "R12 other addr");
    wr(24'h005555, 8'hA0, 1'b0, "R12");
    wr(24'h021234, 8'h02, 1'b1, "R12 prog on");
    seq3(8'hF0);
    wr(24'h002AAA, 8'hAA, 1'b0, "R12");
    wr(24'h002AAA, 8'h55, 1'b0, "R12");
    wr(24'h002AAA, 8'hA0, 1'b0, "R12");
    rd(24'h000002, arr_of(24'h000002), "R12 wrong addr");
    wr(24'h005555, 8'h38, 1'b0, "R12");
    wr(24'h005555, 8'hD0, 1'b0, "R12");
    rd(24'h00FF00, arr_of(24'h00FF00), "R12 id needs 0000");

    // R10 read-only strap
    seq3(8'hA0);
    ro = 1'b1;
    wr(24'h021234, 8'h03, 1'b0, "R10 no program");
    wr(24'h005555, 8'hAA, 1'b0, "R10");
    wr(24'h002AAA, 8'h55, 1'b0, "R10");
    wr(24'h005555, 8'hF0, 1'b0, "R10");
    ro = 1'b0;
    rd(24'h000002, 8'h80, "R10 modes kept");
    wr(24'h021234, 8'h03, 1'b1, "R10 prog kept");
    wr(24'h001234, 8'h00, 1'b1, "R10 prev kept");

    // R8 sweep of all byte values, each written twice
    for (int d = 1; d < 256; d++) begin
      wr(24'h001000, 8'(d), 1'b0, "R8 sweep first");
      wr(24'h001000, 8'(d), 1'b1, "R8 sweep repeat");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule